// File: doc/BRIEF.md
# Edge-Selectable Input Capture Timer

This block is an up-counter with a programmable wrap point and a capture register. It stamps the current count when a chosen edge appears on an external input. Software uses it to measure pulse widths and input periods. A run control starts the counter from zero, and a pause control freezes it without losing its value. A period compare value sets the point where the counter returns to zero. Two sticky interrupt flags report a capture and a period match, and each flag has its own clear strobe.

The external input is asynchronous to the block clock, so it first passes through a two-flop synchroniser. An edge is found by comparing the synchronised sample with the sample taken one clock earlier. A 2-bit edge code selects rising edges, falling edges, both edges, or no capture at all. The counter runs the same way whatever happens on the input.

Top module: `capture_timer`

## Requirements
- R1: While `rst_n` is low, `cap_val` is 0, `cap_flag` is 0, `per_flag` is 0, and the internal count is 0.
- R2: A level change on `cap_pin` that holds steady reaches the capture logic through two synchroniser flops. The resulting capture lands on the third rising clock edge after the change.
- R3: `edge_sel` selects the capture edge: 2'b00 captures on a rising edge, 2'b01 on a falling edge, 2'b10 on either edge, and 2'b11 never captures.
- R4: When a selected edge is detected and `run_en` is high, `cap_val` takes the count as it stood before that clock edge, and `cap_flag` is set. With `run_en` low, no capture happens.
- R5: In the cycle where `run_en` is first seen high after being low, the count is set to 0. After that the count rises by one per clock while `run_en` is high and `pause_en` is low. While `run_en` is low the count holds its value.
- R6: While `run_en` and `pause_en` are both high, the count holds its value. Counting resumes from that value once `pause_en` falls.
- R7: If the count is advancing and equals a nonzero `period_val`, the next count is 0 and `per_flag` is set.
- R8: When `period_val` is 0, the count runs up to 2^CNT_W-1. It then returns to 0 and sets `per_flag`. If the count is already above a nonzero `period_val`, it wraps from 2^CNT_W-1 to 0 without a flag.
- R9: If a capture and a period match happen in the same cycle, `cap_val` receives the value before the return to zero, and both flags are set.
- R10: Each flag stays set until its clear strobe (`cap_clr` or `per_clr`) is sampled high. If a set and a clear occur in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous external capture input |
| run_en | input | 1 | Counter run control; a rising level restarts the count at zero |
| pause_en | input | 1 | Freezes the count while high |
| edge_sel | input | 2 | Capture edge code (see R3) |
| period_val | input | CNT_W | Wrap point; 0 selects the full range |
| cap_clr | input | 1 | Clear strobe for `cap_flag` |
| per_clr | input | 1 | Clear strobe for `per_flag` |
| cap_val | output | CNT_W | Last captured count |
| cap_flag | output | 1 | Sticky capture interrupt flag |
| per_flag | output | 1 | Sticky period-match interrupt flag |

## Verification
The count is internal, so a wrong count shows at the ports only through `cap_val` at the next capture, or through the timing of `per_flag`. A wrong count shows within one period once edges arrive often enough. A stale synchroniser or edge-history flop moves a capture by a cycle or drops it. That changes `cap_val` or `cap_flag` on the cycle the capture should have landed. A flag with the wrong priority shows on the cycle after a set coincides with a clear. The reference model is compared every clock, so each of these shows as a miscompare within a few cycles of its cause.

// File: rtl/capt_pkg.sv
package capt_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'b00,
      EDGE_FALL = 2'b01,
      EDGE_ANY  = 2'b10,
      EDGE_NONE = 2'b11
   } edge_code_e;

   function automatic logic edge_hit(input edge_code_e code,
                                     input logic rise,
                                     input logic fall);
      logic hit;
      case (code)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_ANY:  hit = rise | fall;
         default:   hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/capt_sync.sv
module capt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync,
   output logic q_prev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("capt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              hist;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= 1'b0;
      else        hist <= chain[STAGES-1];
   end

   assign q_sync = chain[STAGES-1];
   assign q_prev = hist;
endmodule

// File: rtl/capt_counter.sv
module capt_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             adv,
   input  logic [CNT_W-1:0] period_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      term = (period_val == '0) ? CNT_MAX : period_val;
      wrap = adv && (cnt == term);
      if (start || wrap) cnt_d = '0;
      else if (adv)      cnt_d = cnt + 1'b1;
      else               cnt_d = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
   end
endmodule

// File: rtl/capt_flag.sv
module capt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/capture_timer.sv
module capture_timer #(
   parameter int CNT_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_pin,
   input  logic             run_en,
   input  logic             pause_en,
   input  logic [1:0]       edge_sel,
   input  logic [CNT_W-1:0] period_val,
   input  logic             cap_clr,
   input  logic             per_clr,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_flag,
   output logic             per_flag
);
   import capt_pkg::*;

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("capture_timer: CNT_W out of range 2..32");
   end

   logic             pin_s, pin_p;
   logic             rise, fall, cap_evt;
   logic             run_q, start, adv, wrap;
   logic [CNT_W-1:0] cnt;

   capt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(cap_pin),
      .q_sync(pin_s), .q_prev(pin_p)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run_en;
   end

   always_comb begin
      rise    = pin_s & ~pin_p;
      fall    = ~pin_s & pin_p;
      cap_evt = run_en & edge_hit(edge_code_e'(edge_sel), rise, fall);
      start   = run_en & ~run_q;
      adv     = run_en & run_q & ~pause_en;
   end

   capt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
      .period_val(period_val), .cnt(cnt), .wrap(wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_val <= '0;
      else if (cap_evt) cap_val <= cnt;
   end

   capt_flag u_cap_flag (
      .clk(clk), .rst_n(rst_n), .set(cap_evt), .clr(cap_clr), .q(cap_flag)
   );

   capt_flag u_per_flag (
      .clk(clk), .rst_n(rst_n), .set(wrap), .clr(per_clr), .q(per_flag)
   );
endmodule

module capt_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             pause_en,
   input logic [1:0]       edge_sel,
   input logic [CNT_W-1:0] period_val,
   input logic             cap_clr,
   input logic             per_clr,
   input logic [CNT_W-1:0] cap_val,
   input logic             cap_flag,
   input logic             per_flag,
   input logic             run_q,
   input logic [CNT_W-1:0] cnt
);
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!cap_flag && !per_flag && cap_val == '0));

   a_r5_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !run_q) |=> (cnt == '0));

   a_r5_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en) |=> $stable(cnt));

   a_r6_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && run_q && pause_en) |=> $stable(cnt));

   a_r7_period_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && run_q && !pause_en && period_val != '0 && cnt == period_val)
      |=> (cnt == '0 && per_flag));

   a_r8_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && run_q && !pause_en && period_val == '0 && cnt == {CNT_W{1'b1}})
      |=> (cnt == '0 && per_flag));

   a_r3_disabled_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel == 2'b11) |=> $stable(cap_val));

   a_r4_idle_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en) |=> $stable(cap_val));

   a_r10_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag && !cap_clr) |=> cap_flag);

   a_r10_per_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (per_flag && !per_clr) |=> per_flag);
endmodule

bind capture_timer capt_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .pause_en(pause_en),
   .edge_sel(edge_sel), .period_val(period_val), .cap_clr(cap_clr),
   .per_clr(per_clr), .cap_val(cap_val), .cap_flag(cap_flag),
   .per_flag(per_flag), .run_q(run_q), .cnt(cnt)
);

// File: tb/test_capture_timer.sv
module test_capture_timer;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W      = 10;
   localparam int MAXC       = (1 << CNT_W) - 1;
   localparam int WDOG       = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cap_pin = 1'b0;
   logic             run_en = 1'b0;
   logic             pause_en = 1'b0;
   logic [1:0]       edge_sel = 2'b00;
   logic [CNT_W-1:0] period_val = '0;
   logic             cap_clr = 1'b0;
   logic             per_clr = 1'b0;
   logic [CNT_W-1:0] cap_val;
   logic             cap_flag;
   logic             per_flag;

   capture_timer #(.CNT_W(CNT_W)) i_capture_timer (
      .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .run_en(run_en),
      .pause_en(pause_en), .edge_sel(edge_sel), .period_val(period_val),
      .cap_clr(cap_clr), .per_clr(per_clr), .cap_val(cap_val),
      .cap_flag(cap_flag), .per_flag(per_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference model
   int m_s1, m_s2, m_s3, m_run, m_cnt, m_cap, m_cf, m_pf;
   int coinc = 0, full_wraps = 0, n_caps = 0;
   int vectors = 0, miscompares = 0;
   string cur_tag = "R1";
   bit done = 1'b0;
   int tog_k = 0, tcnt = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_run = 0;
         m_cnt = 0; m_cap = 0; m_cf = 0; m_pf = 0;
      end else begin
         bit rise, fall, hit, capt, start, adv, wrp;
         int term;
         rise  = (m_s2 == 1) && (m_s3 == 0);
         fall  = (m_s2 == 0) && (m_s3 == 1);
         hit   = (edge_sel == 2'b00 && rise) || (edge_sel == 2'b01 && fall) ||
                 (edge_sel == 2'b10 && (rise || fall));
         capt  = run_en && hit;
         start = run_en && (m_run == 0);
         adv   = run_en && (m_run == 1) && !pause_en;
         term  = (period_val == 0) ? MAXC : int'(period_val);
         wrp   = adv && (m_cnt == term);
         if (capt) begin m_cap = m_cnt; n_caps++; end
         if (capt) m_cf = 1; else if (cap_clr) m_cf = 0;
         if (wrp) m_pf = 1; else if (per_clr) m_pf = 0;
         if (capt && wrp) coinc++;
         if (wrp && period_val == 0) full_wraps++;
         if (start || wrp) m_cnt = 0;
         else if (adv)     m_cnt = (m_cnt + 1) % (MAXC + 1);
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(cap_pin); m_run = int'(run_en);
      end
   end

   task automatic check(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (!done) begin
      check(cur_tag, "cap_val",  int'(cap_val),  m_cap);
      check(cur_tag, "cap_flag", int'(cap_flag), m_cf);
      check(cur_tag, "per_flag", int'(per_flag), m_pf);
   end

   task automatic cyc(int n);
      repeat (n) begin
         @(negedge clk); #1;
         tcnt++;
         if (tog_k != 0 && (tcnt % tog_k) == 0) cap_pin = ~cap_pin;
      end
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      cur_tag = "R1";
      cyc(4);
      check("R1", "cap_val in reset", int'(cap_val), 0);
      rst_n = 1'b1;
      cyc(3);

      // R5: start from zero; R4: no capture while stopped
      cur_tag = "R4";
      tog_k = 7; cyc(40);
      cur_tag = "R5";
      period_val = 10'd50; run_en = 1'b1; tog_k = 0; cyc(20);

      // R2 and R3 rising edge: single clean edge, capture on third clock
      cur_tag = "R2";
      edge_sel = 2'b00; cap_clr = 1'b1; cyc(1); cap_clr = 1'b0;
      cap_pin = 1'b1; cyc(6); cap_pin = 1'b0; cyc(10);

      // R3: each edge code under a periodic pin
      cur_tag = "R3";
      tog_k = 9;
      edge_sel = 2'b00; cyc(80);
      edge_sel = 2'b01; cyc(80);
      edge_sel = 2'b10; cyc(80);
      edge_sel = 2'b11; cyc(80);

      // R6: pause windows
      cur_tag = "R6";
      edge_sel = 2'b10; tog_k = 5;
      for (int i = 0; i < 5; i++) begin
         pause_en = 1'b1; cyc(7 + i);
         pause_en = 1'b0; cyc(13);
      end

      // R7: short periods with flag clears
      cur_tag = "R7";
      for (int p = 3; p < 9; p++) begin
         period_val = CNT_W'(p);
         cyc(30);
         per_clr = 1'b1; cyc(1); per_clr = 1'b0;
      end

      // R9: both-edge captures racing a short period
      cur_tag = "R9";
      period_val = 10'd4; edge_sel = 2'b10; tog_k = 3; cyc(200);

      // R10: clear strobes held while sets keep arriving
      cur_tag = "R10";
      tog_k = 1; cap_clr = 1'b1; per_clr = 1'b1; cyc(40);
      tog_k = 0; cyc(6); cyc(10);
      cap_clr = 1'b0; per_clr = 1'b0; cyc(10);

      // R5: stop holds, restart clears
      cur_tag = "R5";
      period_val = 10'd100; tog_k = 4; cyc(20);
      run_en = 1'b0; cyc(30);
      run_en = 1'b1; cyc(60);

      // R8: zero period uses the full range
      cur_tag = "R8";
      period_val = '0; tog_k = 37; per_clr = 1'b1; cyc(1); per_clr = 1'b0;
      cyc(2 * (MAXC + 1) + 50);
      // R8: count above a lowered nonzero period rolls over silently
      period_val = 10'd5; cyc(MAXC + 40);

      // random mix
      cur_tag = "R4";
      for (int i = 0; i < 3000; i++) begin
         cap_pin  = ($urandom % 3) == 0 ? ~cap_pin : cap_pin;
         pause_en = ($urandom % 10) == 0;
         cap_clr  = ($urandom % 8) == 0;
         per_clr  = ($urandom % 8) == 0;
         if (($urandom % 300) == 0) edge_sel = 2'($urandom);
         if (($urandom % 500) == 0) run_en = ~run_en;
         if (($urandom % 400) == 0) period_val = CNT_W'($urandom % 40);
         @(negedge clk); #1;
      end

      check("R9", "coincident capture and match seen", int'(coinc > 0), 1);
      check("R8", "full-range wraps seen", int'(full_wraps >= 2), 1);
      check("R4", "captures seen", int'(n_caps > 20), 1);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule